// File: doc/BRIEF.md
# Two-Wire Byte-Store Slave

This block lets an external master on a two-wire serial bus read and write a small on-chip byte store. It never starts a transfer itself. It oversamples the clock and data lines with the fast system clock. From those samples it finds the bus start and stop events, shifts bytes in and out MSB first, and drives the data line low through an open-drain style enable. That enable is used for acknowledges and for outgoing zero bits.

A transaction opens with a selection byte. Its upper nibble must equal a fixed device type code (1010). Its next two bits must equal two strap inputs, so up to four of these slaves can share one bus. The bit after that picks one of two 256-byte blocks, and the last bit gives the direction (1 read, 0 write). A write carries one word-address byte and then any number of data bytes. A read streams bytes out from the current pointer for as long as the master acknowledges. The pointer advances after every byte and wraps inside the selected block. When a write that stored data is closed by a stop, the block raises a one-cycle commit request and then stays busy for a fixed number of cycles. While it is busy, it refuses selection bytes.

Top module: `twoWireMemSlave`

## Requirements
- R1: After reset and while the bus is idle, sdaDriveLow and commitPulse are both 0.
- R2: A selection byte whose bits [7:4] are 1010 and bits [3:2] equal strapSel is acknowledged: sdaDriveLow is 1 throughout the high phase of the ninth clock.
- R3: A selection byte with a wrong type code or wrong select bits gets no acknowledge, and every later byte is ignored, with nothing stored, until the next start.
- R4: In a write, the byte after the selection byte loads the word pointer. Each later byte is acknowledged and stored at the pointer, and then the pointer increments.
- R5: The pointer wraps from 255 to 0 inside the same block and never reaches the other block.
- R6: Bit [1] of the selection byte selects the block. The same word address in the two blocks holds independent data.
- R7: In a read, bytes go out MSB first from the pointer, and the pointer advances once per byte. After a master acknowledge on the ninth clock, the next byte follows at once.
- R8: After a master non-acknowledge, and after any stop, the slave releases SDA and drives nothing until the next start.
- R9: A stop that ends a write in which at least one data byte was stored gives commitPulse high for exactly one cycle, three system clocks after SDA rises. Reads, and writes with no stored data, give no pulse.
- R10: For BUSY_CYCLES cycles after a commit pulse, selection bytes get no acknowledge.
- R11: A repeated start restarts selection decoding, so a word-address write followed by a read in the same transfer reads from that address.
- R12: sdaDriveLow changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad (wired level) |
| strapSel | input | 2 | Strapped device-select bits compared against selection byte bits [3:2] |
| sdaDriveLow | output | 1 | 1 pulls the data line low; 0 releases it |
| commitPulse | output | 1 | One-cycle request to start the internal write cycle |

## Verification
Each line change at the pads passes two synchroniser flops, and the state register then acts one clock later. sdaDriveLow and commitPulse therefore move three system clocks after the pad edge that causes them. The master model holds every SCL phase for ten system clocks. It changes SDA five clocks into the low phase and samples the wired line five clocks into the high phase, so acknowledges and read bits are judged long after they settle. The commit pulse is compared on every clock against the exact cycle the reference model predicts, the SDA-rise cycle plus three, so an early, late or wide pulse is reported. Stored data is judged only through reads at the ports.

// File: rtl/tws_pkg.sv
package tws_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK,
    ST_SKIP
  } busState_t;

  typedef enum logic [1:0] {
    RX_ADDR,
    RX_WORD,
    RX_DATA
  } rxKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic sampleBit;
    logic countBit;
    logic clearBits;
    logic takeAddr;
    logic takeWord;
    logic storeByte;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclSync,
  output logic sdaSync,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [1:0] rawIn;
  logic [1:0] syncOut;
  logic [1:0] lastOut;

  assign rawIn = {sdaIn, sclIn};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[STAGES-2:0], rawIn[g]};
    end
    assign syncOut[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastOut <= '1;
    else       lastOut <= syncOut;
  end

  assign sclSync  = syncOut[0];
  assign sdaSync  = syncOut[1];
  assign sclRise  = syncOut[0] & ~lastOut[0];
  assign sclFall  = ~syncOut[0] & lastOut[0];
  // both lines high before, clock still high, data moves
  assign startDet = syncOut[0] & lastOut[0] & lastOut[1] & ~syncOut[1];
  assign stopDet  = syncOut[0] & lastOut[0] & ~lastOut[1] & syncOut[1];

endmodule

// File: rtl/tws_datapath.sv
module tws_datapath
  import tws_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter logic [3:0] TYPE_CODE = 4'b1010
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t stb,
  input  logic      sdaBit,
  input  logic [1:0] strapSel,
  output logic      addrMatch,
  output logic      addrRw,
  output logic      bitsDone,
  output logic      txNext,
  output logic      rdMsb
);

  localparam int NUM_WORDS = 2 ** (ADDR_W + 1);
  localparam int CNT_W     = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] txShift;
  logic [CNT_W-1:0]  bitCnt;
  logic              blkSel;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W:0]   memAddr;
  logic [BYTE_W-1:0] rdWord;
  logic [BYTE_W-1:0] store [NUM_WORDS];

  assign memAddr = {blkSel, ptr};
  assign rdWord  = store[memAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      bitCnt  <= '0;
      blkSel  <= 1'b0;
      ptr     <= '0;
    end else begin
      if (stb.clearBits)                      bitCnt <= '0;
      else if (stb.sampleBit || stb.countBit) bitCnt <= bitCnt + 1'b1;

      if (stb.sampleBit) rxShift <= {rxShift[BYTE_W-2:0], sdaBit};

      if (stb.takeAddr) blkSel <= rxShift[1];

      if (stb.takeWord)                      ptr <= rxShift[ADDR_W-1:0];
      else if (stb.storeByte || stb.loadTx)  ptr <= ptr + 1'b1;

      if (stb.loadTx)       txShift <= rdWord;
      else if (stb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (stb.storeByte) store[memAddr] <= rxShift;
  end

  assign addrMatch = (rxShift[7:4] == TYPE_CODE) && (rxShift[3:2] == strapSel);
  assign addrRw    = rxShift[0];
  assign bitsDone  = (bitCnt == CNT_W'(BYTE_W));
  assign txNext    = txShift[BYTE_W-2];
  assign rdMsb     = rdWord[BYTE_W-1];

endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter int BUSY_CYCLES = 400
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startDet,
  input  logic      stopDet,
  input  logic      sdaBit,
  input  logic      addrMatch,
  input  logic      addrRw,
  input  logic      bitsDone,
  input  logic      txNext,
  input  logic      rdMsb,
  output dpStrobe_t stb,
  output logic      sdaDriveLow,
  output logic      commitPulse
);

  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  busState_t         state, stateNxt;
  rxKind_t           kind, kindNxt;
  logic              isRead, readNxt;
  logic              sdaLow, sdaNxt;
  logic              pending, pendNxt;
  logic              masterAck, mAckNxt;
  logic              commitQ, commitNxt;
  logic [BUSY_W-1:0] busyCnt;
  logic              busy;

  assign busy = (busyCnt != '0);

  always_comb begin
    stb       = '0;
    stateNxt  = state;
    kindNxt   = kind;
    readNxt   = isRead;
    sdaNxt    = sdaLow;
    pendNxt   = pending;
    mAckNxt   = masterAck;
    commitNxt = 1'b0;
    if (stopDet) begin
      stateNxt  = ST_IDLE;
      sdaNxt    = 1'b0;
      commitNxt = pending;
      pendNxt   = 1'b0;
      mAckNxt   = 1'b0;
    end else if (startDet) begin
      stateNxt      = ST_RX;
      kindNxt       = RX_ADDR;
      stb.clearBits = 1'b1;
      sdaNxt        = 1'b0;
      pendNxt       = 1'b0;
      mAckNxt       = 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (sclRise && !bitsDone) begin
            stb.sampleBit = 1'b1;
          end else if (sclFall && bitsDone) begin
            unique case (kind)
              RX_ADDR: begin
                if (addrMatch && !busy) begin
                  stb.takeAddr = 1'b1;
                  readNxt      = addrRw;
                  sdaNxt       = 1'b1;
                  stateNxt     = ST_ACK;
                end else begin
                  stateNxt = ST_SKIP;
                end
              end
              RX_WORD: begin
                stb.takeWord = 1'b1;
                sdaNxt       = 1'b1;
                stateNxt     = ST_ACK;
              end
              default: begin
                stb.storeByte = 1'b1;
                pendNxt       = 1'b1;
                sdaNxt        = 1'b1;
                stateNxt      = ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            stb.clearBits = 1'b1;
            if (isRead) begin
              stb.loadTx = 1'b1;
              sdaNxt     = !rdMsb;
              stateNxt   = ST_TX;
            end else begin
              sdaNxt   = 1'b0;
              kindNxt  = (kind == RX_ADDR) ? RX_WORD : RX_DATA;
              stateNxt = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (sclRise) begin
            stb.countBit = 1'b1;
          end else if (sclFall) begin
            if (bitsDone) begin
              sdaNxt        = 1'b0;
              stb.clearBits = 1'b1;
              mAckNxt       = 1'b0;
              stateNxt      = ST_TXACK;
            end else begin
              stb.shiftTx = 1'b1;
              sdaNxt      = !txNext;
            end
          end
        end
        ST_TXACK: begin
          if (sclRise) begin
            if (!sdaBit) mAckNxt  = 1'b1;
            else         stateNxt = ST_SKIP;
          end else if (sclFall && masterAck) begin
            stb.loadTx = 1'b1;
            mAckNxt    = 1'b0;
            sdaNxt     = !rdMsb;
            stateNxt   = ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kind      <= RX_ADDR;
      isRead    <= 1'b0;
      sdaLow    <= 1'b0;
      pending   <= 1'b0;
      masterAck <= 1'b0;
      commitQ   <= 1'b0;
      busyCnt   <= '0;
    end else begin
      state     <= stateNxt;
      kind      <= kindNxt;
      isRead    <= readNxt;
      sdaLow    <= sdaNxt;
      pending   <= pendNxt;
      masterAck <= mAckNxt;
      commitQ   <= commitNxt;
      if (commitNxt) busyCnt <= BUSY_W'(BUSY_CYCLES);
      else if (busy) busyCnt <= busyCnt - 1'b1;
    end
  end

  assign sdaDriveLow = sdaLow;
  assign commitPulse = commitQ;

endmodule

// File: rtl/twoWireMemSlave.sv
module twoWireMemSlave
  import tws_pkg::*;
#(
  parameter logic [3:0] TYPE_CODE   = 4'b1010,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter int         BUSY_CYCLES = 400
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] strapSel,
  output logic       sdaDriveLow,
  output logic       commitPulse
);

  logic      sclSync, sdaSync, sclRise, sclFall, startDet, stopDet;
  logic      addrMatch, addrRw, bitsDone, txNext, rdMsb;
  dpStrobe_t dpStb;

  tws_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclSync(sclSync), .sdaSync(sdaSync), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  tws_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaSync),
    .addrMatch(addrMatch), .addrRw(addrRw), .bitsDone(bitsDone),
    .txNext(txNext), .rdMsb(rdMsb), .stb(dpStb),
    .sdaDriveLow(sdaDriveLow), .commitPulse(commitPulse)
  );

  tws_datapath #(.ADDR_W(ADDR_W), .TYPE_CODE(TYPE_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .stb(dpStb), .sdaBit(sdaSync), .strapSel(strapSel),
    .addrMatch(addrMatch), .addrRw(addrRw), .bitsDone(bitsDone),
    .txNext(txNext), .rdMsb(rdMsb)
  );

endmodule

// File: rtl/twoWireMemSlave_chk.sv
module twoWireMemSlave_chk (
  input logic clk,
  input logic rstN,
  input logic sdaDriveLow,
  input logic commitPulse,
  input logic sclSync,
  input logic startDet,
  input logic stopDet
);

  // R12: the data drive only moves while the clock line is low
  p_sda_moves_scl_low_r12: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclSync);

  // R9: commit request lasts one cycle
  p_commit_width_r9: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |=> !commitPulse);

  // R9: commit request only follows a stop event
  p_commit_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> $past(stopDet));

  // R8: a stop leaves the line released
  p_stop_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaDriveLow);

  // R11: a start leaves the line released for the new selection byte
  p_start_release_r11: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaDriveLow);

endmodule

bind twoWireMemSlave twoWireMemSlave_chk u_chk (
  .clk(clk), .rstN(rstN), .sdaDriveLow(sdaDriveLow), .commitPulse(commitPulse),
  .sclSync(sclSync), .startDet(startDet), .stopDet(stopDet)
);

// File: tb/tb_twoWireMemSlave.sv
`timescale 1ns/1ps
module tb_twoWireMemSlave;

  localparam int H    = 10;
  localparam int BUSY = 400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [1:0] strap = 2'b10;
  logic drv, commit;
  logic sdaLine;

  assign sdaLine = sdaM & ~drv;

  always #2.5 clk = ~clk;

  twoWireMemSlave #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .strapSel(strap),
    .sdaDriveLow(drv), .commitPulse(commit)
  );

  int cyc = 0;
  int tests = 0;
  int fails = 0;
  int expCommitCyc = -1;
  int commitSeen = 0;
  int commitWant = 0;
  logic [7:0] refMem [512];
  int refPtr = 0;
  int refBlk = 0;
  bit refPending = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // R9: commit pulse compared against the model on every clock
  always @(negedge clk) begin
    if (rstN) begin
      if (cyc == expCommitCyc) tests++;
      if (commit !== (cyc == expCommitCyc)) begin
        fails++;
        $display("FAIL R9 commit at cycle %0d: got %0b expected %0b", cyc, commit, cyc == expCommitCyc);
      end
      if (commit === 1'b1) commitSeen++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    idle(H/2); sdaM = 1'b1; idle(H/2); sclM = 1'b1; idle(H);
    sdaM = 1'b0; idle(H); sclM = 1'b0;
    refPending = 0;
  endtask

  task automatic stopCond();
    idle(H/2); sdaM = 1'b0; idle(H/2); sclM = 1'b1; idle(H);
    sdaM = 1'b1;
    if (refPending) begin
      expCommitCyc = cyc + 3;
      commitWant++;
    end
    refPending = 0;
    idle(H);
  endtask

  task automatic clockBit(input logic b, output logic seen);
    idle(H/2); sdaM = b; idle(H/2); sclM = 1'b1;
    idle(H/2); seen = sdaLine; idle(H/2); sclM = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(v[i], s);
    clockBit(1'b1, s);
    acked = !s;
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      v[i] = s;
    end
    clockBit(!ackIt, s);
  endtask

  function automatic logic [7:0] selByte(input logic [3:0] typ, input logic [1:0] sel,
                                         input logic blk, input logic rd);
    return {typ, sel, blk, rd};
  endfunction

  task automatic writeSeq(input logic blk, input logic [7:0] word,
                          input logic [7:0] d [4], input int n);
    logic a;
    startCond();
    sendByte(selByte(4'b1010, strap, blk, 1'b0), a);
    chk("R2 write selection ack", a, 1);
    refBlk = blk;
    sendByte(word, a);
    chk("R4 word address ack", a, 1);
    refPtr = word;
    for (int k = 0; k < n; k++) begin
      sendByte(d[k], a);
      chk("R4 data byte ack", a, 1);
      refMem[refBlk*256 + refPtr] = d[k];
      refPtr = (refPtr + 1) % 256;
      refPending = 1;
    end
    stopCond();
  endtask

  task automatic setPtr(input logic blk, input logic [7:0] word);
    logic a;
    startCond();
    sendByte(selByte(4'b1010, strap, blk, 1'b0), a);
    chk("R11 pointer-set selection ack", a, 1);
    sendByte(word, a);
    chk("R11 pointer-set word ack", a, 1);
    refBlk = blk;
    refPtr = word;
  endtask

  task automatic readSeq(input logic blk, input int n, input string tag);
    logic a;
    logic [7:0] v;
    startCond();
    sendByte(selByte(4'b1010, strap, blk, 1'b1), a);
    chk("R2 read selection ack", a, 1);
    refBlk = blk;
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, v);
      chk(tag, v, refMem[refBlk*256 + refPtr]);
      refPtr = (refPtr + 1) % 256;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] v;
    idle(5);
    rstN = 1'b1;
    idle(5);
    chk("R1 idle drive", drv, 0);
    chk("R1 idle commit", commit, 0);

    // R4 R9: four data bytes then stop
    writeSeq(1'b0, 8'h10, '{8'hA5, 8'h3C, 8'h0F, 8'hC3}, 4);

    // R10: immediate retry lands inside the busy window
    startCond();
    sendByte(selByte(4'b1010, strap, 1'b0, 1'b0), a);
    chk("R10 selection refused while busy", a, 0);
    stopCond();
    idle(BUSY + 50);

    // R11 R7 R8: random read, three bytes, NACK on the last
    setPtr(1'b0, 8'h10);
    readSeq(1'b0, 3, "R7 streamed read byte");
    recvByte(1'b0, v);
    chk("R8 line released after NACK", v, 8'hFF);
    stopCond();
    // R7: current-pointer read continues at 0x13
    readSeq(1'b0, 1, "R7 current pointer read");
    stopCond();

    // R6: same word address in the other block
    writeSeq(1'b1, 8'h10, '{8'h77, 8'h00, 8'h00, 8'h00}, 1);
    idle(BUSY + 50);
    setPtr(1'b1, 8'h10);
    readSeq(1'b1, 1, "R6 block one byte");
    stopCond();
    setPtr(1'b0, 8'h10);
    readSeq(1'b0, 1, "R6 block zero untouched");
    stopCond();

    // R5: wrap inside block one, block zero word 0 must survive
    writeSeq(1'b0, 8'h00, '{8'h5A, 8'h00, 8'h00, 8'h00}, 1);
    idle(BUSY + 50);
    writeSeq(1'b1, 8'hFE, '{8'h11, 8'h22, 8'h33, 8'h00}, 3);
    idle(BUSY + 50);
    setPtr(1'b1, 8'hFE);
    readSeq(1'b1, 3, "R5 wrapped read in block one");
    stopCond();
    setPtr(1'b0, 8'h00);
    readSeq(1'b0, 1, "R5 block zero word 0 kept");
    stopCond();

    // R3: wrong type code, then wrong select bits
    startCond();
    sendByte(selByte(4'b1011, strap, 1'b0, 1'b0), a);
    chk("R3 wrong type not acked", a, 0);
    sendByte(8'h10, a);
    chk("R3 later byte ignored", a, 0);
    sendByte(8'hEE, a);
    chk("R3 data byte ignored", a, 0);
    stopCond();
    startCond();
    sendByte(selByte(4'b1010, ~strap, 1'b0, 1'b0), a);
    chk("R3 wrong select not acked", a, 0);
    sendByte(8'h10, a);
    sendByte(8'hEE, a);
    chk("R3 data after wrong select ignored", a, 0);
    stopCond();
    setPtr(1'b0, 8'h10);
    readSeq(1'b0, 1, "R3 store unchanged");
    stopCond();

    // R2: strap change moves the device address
    strap = 2'b01;
    idle(10);
    setPtr(1'b0, 8'h11);
    readSeq(1'b0, 1, "R2 new strap read");
    stopCond();

    idle(20);
    chk("R1 idle drive at end", drv, 0);
    chk("R9 commit pulse count", commitSeen, commitWant);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule